// File: doc/BRIEF.md
# System Reset Sequencer

This block merges the chip's reset sources into one synchronous system reset. It also runs a fixed-length stabilisation count before the processor core may start fetching. The sources are a power-on flag, an active-low external reset pin and a brown-out comparator with its own enable bit. The power-on flag acts as the block's asynchronous reset. The pin and the comparator are asynchronous and each passes through a two-flop synchronizer. The analog detectors appear only as digital levels.

A low on the external pin counts only once it has been seen on enough consecutive clock edges. Once qualified, it holds the system in reset and puts the oscillator and analog blocks into a low-power hold until the pin returns high. The rising edge of the pin starts the stabilisation count. A brown-out holds reset while the supply is low, provided detection is enabled, and starts the count once the supply has recovered. The core is released one cycle after the system reset drops. A small status output records which source caused the most recent reset.

Top module: `sysrst_sequencer`

## Requirements
- R1: While `por_req` is high, `sys_rst`=1, `core_hold`=1, `lp_hold`=0 and `rst_cause`=2'b01. After `por_req` falls, `sys_rst` stays high for 2 synchronizer cycles plus SEQ_LEN cycles. It drops on the (2+SEQ_LEN)-th rising clock edge after the release.
- R2: `ext_rst_n` is active low, and a high level means idle. A low seen on PIN_MIN_CYC consecutive synchronized samples qualifies as a reset. It asserts `sys_rst` and `lp_hold` and sets `rst_cause` to 2'b10.
- R3: A low pulse on `ext_rst_n` shorter than PIN_MIN_CYC clock cycles has no effect on any output.
- R4: `lp_hold` is high only while a qualified pin reset is held low. It is never high without `sys_rst`.
- R5: When a qualified pin returns high, `lp_hold` drops. `sys_rst` then stays high for SEQ_LEN further cycles before releasing.
- R6: `core_hold` is high whenever `sys_rst` is high, and for exactly one more cycle after `sys_rst` falls.
- R7: With `bod_en`=1, a synchronized high on `bod_low` holds `sys_rst` and sets `rst_cause` to 2'b11. After `bod_low` falls, a SEQ_LEN-cycle stabilisation count runs.
- R8: With `bod_en`=0, `bod_low` has no effect on any output.
- R9: A qualified pin reset takes priority over a brown-out hold. A pin or brown-out hold that arrives during the stabilisation count restarts the count. `rst_cause` keeps its value until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| por_req | input | 1 | Power-on detect, active high, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| bod_low | input | 1 | Brown-out comparator: supply below threshold |
| bod_en | input | 1 | Brown-out detection enable |
| sys_rst | output | 1 | System reset to all registers, active high |
| core_hold | output | 1 | Keeps the core from executing |
| lp_hold | output | 1 | Low-power hold for oscillator and analog blocks |
| rst_cause | output | 2 | Last reset source: 01 power-on, 10 pin, 11 brown-out |

## Verification
The assertions check on every cycle how the three hold outputs relate to each other. The low-power hold never appears without the system reset, and the core hold covers the system reset and outlasts it by one cycle. A pin release is always followed by a stabilisation period, and the cause code is never empty. Only the bench scenarios can show the timing: the exact qualification boundary of PIN_MIN_CYC cycles, the length of the stabilisation count, and that a brown-out is ignored while disabled. They also show the priority between a pin hold and a brown-out hold, and that a hold arriving mid-count restarts the count.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;
  typedef enum logic [1:0] {
    ST_RUN = 2'd0,
    ST_PIN = 2'd1,
    ST_BOD = 2'd2,
    ST_SEQ = 2'd3
  } rst_state_e;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_POR  = 2'd1,
    CAUSE_PIN  = 2'd2,
    CAUSE_BOD  = 2'd3
  } rst_cause_e;
endpackage

// File: rtl/sysrst_sync.sv
module sysrst_sync #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst,
  input  logic d,
  output logic q
);
  logic s1;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      s1 <= RST_VAL;
      q  <= RST_VAL;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/sysrst_pinqual.sv
module sysrst_pinqual #(
  parameter int MIN_CYC = 10
) (
  input  logic clk,
  input  logic arst,
  input  logic pin_s,
  output logic pin_long
);
  localparam int CW = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] SAT = CW'(MIN_CYC);
  localparam logic [CW-1:0] THR = CW'(MIN_CYC - 1);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      low_cnt <= '0;
    end else if (pin_s) begin
      low_cnt <= '0;
    end else if (low_cnt != SAT) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  // current sample is the MIN_CYC-th consecutive low one
  assign pin_long = !pin_s && (low_cnt >= THR);
endmodule

// File: rtl/sysrst_fsm.sv
module sysrst_fsm
  import sysrst_pkg::*;
#(
  parameter int SEQ_LEN = 16
) (
  input  logic         clk,
  input  logic         arst,
  input  logic         run_en,
  input  logic         pin_long,
  input  logic         bod_hold,
  output rst_state_e   state,
  output rst_cause_e   cause
);
  localparam int SW = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;
  localparam logic [SW-1:0] LAST = SW'(SEQ_LEN - 1);

  logic [SW-1:0] seq_cnt;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      state   <= ST_SEQ;
      cause   <= CAUSE_POR;
      seq_cnt <= '0;
    end else if (!run_en) begin
      state   <= ST_SEQ;
      seq_cnt <= '0;
    end else if (pin_long) begin
      state <= ST_PIN;
      cause <= CAUSE_PIN;
    end else if (state == ST_PIN) begin
      state   <= ST_SEQ;
      seq_cnt <= '0;
    end else if (bod_hold) begin
      state <= ST_BOD;
      cause <= CAUSE_BOD;
    end else if (state == ST_BOD) begin
      state   <= ST_SEQ;
      seq_cnt <= '0;
    end else if (state == ST_SEQ) begin
      if (seq_cnt == LAST) begin
        state <= ST_RUN;
      end else begin
        seq_cnt <= seq_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sysrst_sequencer.sv
module sysrst_sequencer
  import sysrst_pkg::*;
#(
  parameter int PIN_MIN_CYC = 10,
  parameter int SEQ_LEN     = 16
) (
  input  logic       clk,
  input  logic       por_req,
  input  logic       ext_rst_n,
  input  logic       bod_low,
  input  logic       bod_en,
  output logic       sys_rst,
  output logic       core_hold,
  output logic       lp_hold,
  output logic [1:0] rst_cause
);
  logic       pin_s, bod_s, run_en, pin_long, core_q;
  rst_state_e state;
  rst_cause_e cause;

  sysrst_sync #(.RST_VAL(1'b1)) u_pin_sync (
    .clk(clk), .arst(por_req), .d(ext_rst_n), .q(pin_s));
  sysrst_sync #(.RST_VAL(1'b0)) u_bod_sync (
    .clk(clk), .arst(por_req), .d(bod_low), .q(bod_s));
  sysrst_sync #(.RST_VAL(1'b0)) u_rel_sync (
    .clk(clk), .arst(por_req), .d(1'b1), .q(run_en));

  sysrst_pinqual #(.MIN_CYC(PIN_MIN_CYC)) u_pinqual (
    .clk(clk), .arst(por_req), .pin_s(pin_s), .pin_long(pin_long));

  sysrst_fsm #(.SEQ_LEN(SEQ_LEN)) u_fsm (
    .clk(clk), .arst(por_req), .run_en(run_en), .pin_long(pin_long),
    .bod_hold(bod_en && bod_s), .state(state), .cause(cause));

  always_ff @(posedge clk or posedge por_req) begin
    if (por_req) core_q <= 1'b1;
    else         core_q <= sys_rst;
  end

  assign sys_rst   = (state != ST_RUN);
  assign lp_hold   = (state == ST_PIN);
  assign core_hold = sys_rst | core_q;
  assign rst_cause = cause;
endmodule

// File: rtl/sysrst_sequencer_chk.sv
module sysrst_sequencer_chk (
  input logic       clk,
  input logic       por_req,
  input logic       ext_rst_n,
  input logic       sys_rst,
  input logic       core_hold,
  input logic       lp_hold,
  input logic [1:0] rst_cause
);
  // R4
  lp_needs_rst_chk: assert property (@(posedge clk) disable iff (por_req)
    lp_hold |-> sys_rst);

  // R6
  core_covers_rst_chk: assert property (@(posedge clk) disable iff (por_req)
    sys_rst |-> core_hold);

  // R6
  core_lags_rst_chk: assert property (@(posedge clk) disable iff (por_req)
    $fell(sys_rst) |-> core_hold);

  // R6
  core_rise_with_rst_chk: assert property (@(posedge clk) disable iff (por_req)
    $rose(core_hold) |-> sys_rst);

  // R5
  pin_release_seq_chk: assert property (@(posedge clk) disable iff (por_req)
    $fell(lp_hold) |-> sys_rst);

  // R5
  no_release_from_pin_chk: assert property (@(posedge clk) disable iff (por_req)
    $fell(sys_rst) |-> !$past(lp_hold));

  // R9
  cause_valid_chk: assert property (@(posedge clk) disable iff (por_req)
    rst_cause != 2'b00);
endmodule

bind sysrst_sequencer sysrst_sequencer_chk u_chk (
  .clk(clk), .por_req(por_req), .ext_rst_n(ext_rst_n), .sys_rst(sys_rst),
  .core_hold(core_hold), .lp_hold(lp_hold), .rst_cause(rst_cause));

// File: tb/sysrst_sequencer_tb.sv
module sysrst_sequencer_tb;
  localparam int PMIN = 10;
  localparam int SLEN = 16;

  logic clk = 1'b0;
  logic por_req = 1'b0;
  logic ext_rst_n = 1'b1;
  logic bod_low = 1'b0;
  logic bod_en = 1'b0;
  logic sys_rst, core_hold, lp_hold;
  logic [1:0] rst_cause;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  sysrst_sequencer #(.PIN_MIN_CYC(PMIN), .SEQ_LEN(SLEN)) u_dut (
    .clk(clk), .por_req(por_req), .ext_rst_n(ext_rst_n), .bod_low(bod_low),
    .bod_en(bod_en), .sys_rst(sys_rst), .core_hold(core_hold),
    .lp_hold(lp_hold), .rst_cause(rst_cause));

  always #5 clk = ~clk;

  // behavioural reference: 0 run, 1 pin hold, 2 brown-out hold, 3 counting
  int m_pin[$], m_bod[$];
  int m_rel, m_low, m_mode, m_left, m_cause, m_prev_rst;

  function automatic int m_sys();
    return (m_mode != 0) ? 1 : 0;
  endfunction

  always @(posedge clk or posedge por_req) begin
    if (por_req) begin
      m_pin = '{1, 1}; m_bod = '{0, 0};
      m_rel = 0; m_low = 0; m_mode = 3; m_left = SLEN;
      m_cause = 1; m_prev_rst = 1;
    end else begin
      int pin_now, bod_now;
      pin_now = m_pin[0];
      bod_now = m_bod[0];
      m_prev_rst = m_sys();
      if (m_rel < 2) begin
        m_mode = 3; m_left = SLEN;
      end else if (pin_now == 0 && m_low + 1 >= PMIN) begin
        m_mode = 1; m_cause = 2;
      end else if (m_mode == 1) begin
        m_mode = 3; m_left = SLEN;
      end else if (bod_en && bod_now == 1) begin
        m_mode = 2; m_cause = 3;
      end else if (m_mode == 2) begin
        m_mode = 3; m_left = SLEN;
      end else if (m_mode == 3) begin
        m_left--;
        if (m_left == 0) m_mode = 0;
      end
      m_low = (pin_now == 0) ? m_low + 1 : 0;
      if (m_rel < 2) m_rel++;
      void'(m_pin.pop_front()); m_pin.push_back(int'(ext_rst_n));
      void'(m_bod.pop_front()); m_bod.push_back(int'(bod_low));
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 2) begin
      int exp_core;
      exp_core = (m_sys() == 1 || m_prev_rst == 1) ? 1 : 0;
      chk(int'(sys_rst) == m_sys(), "R1/R5/R7 sys_rst", int'(sys_rst), m_sys());
      chk(int'(core_hold) == exp_core, "R6 core_hold", int'(core_hold), exp_core);
      chk(int'(lp_hold) == ((m_mode == 1) ? 1 : 0), "R4 lp_hold", int'(lp_hold),
          (m_mode == 1) ? 1 : 0);
      chk(int'(rst_cause) == m_cause, "R9 rst_cause", int'(rst_cause), m_cause);
    end
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d: actual 1 expected 0", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pin_pulse(input int n);
    ext_rst_n = 1'b0;
    wait_cyc(n);
    ext_rst_n = 1'b1;
  endtask

  initial begin
    #1 por_req = 1'b1;
    wait_cyc(4);
    // R1 reset state
    chk(sys_rst && core_hold && !lp_hold && rst_cause == 2'b01, "R1 reset state",
        {sys_rst, core_hold, lp_hold, rst_cause}, 5'b11001);
    por_req = 1'b0;
    wait_cyc(2 + SLEN - 1);
    chk(sys_rst == 1'b1, "R1 still held before last edge", int'(sys_rst), 1);
    wait_cyc(1);
    chk(sys_rst == 1'b0, "R1 released after 2+SEQ_LEN edges", int'(sys_rst), 0);
    chk(core_hold == 1'b1, "R6 core held one extra cycle", int'(core_hold), 1);
    wait_cyc(1);
    chk(core_hold == 1'b0, "R6 core released", int'(core_hold), 0);

    // R3 short pulse
    wait_cyc(5);
    pin_pulse(PMIN - 1);
    wait_cyc(6);
    chk(!sys_rst && !lp_hold && rst_cause == 2'b01, "R3 short pulse ignored",
        {sys_rst, lp_hold, rst_cause}, 4'b0001);

    // R2 exact-length pulse qualifies
    pin_pulse(PMIN);
    wait_cyc(2);
    chk(sys_rst && lp_hold && rst_cause == 2'b10, "R2 qualified pin",
        {sys_rst, lp_hold, rst_cause}, 4'b1110);
    wait_cyc(SLEN + 6);
    chk(!sys_rst && !core_hold, "R5 released after sequence",
        {sys_rst, core_hold}, 2'b00);

    // R2 long hold, R4 low-power hold during it
    ext_rst_n = 1'b0;
    wait_cyc(PMIN + 10);
    chk(lp_hold == 1'b1, "R4 lp_hold while pin held", int'(lp_hold), 1);
    ext_rst_n = 1'b1;
    wait_cyc(4);
    chk(!lp_hold && sys_rst, "R5 sequence after rising edge", {lp_hold, sys_rst}, 2'b01);
    wait_cyc(SLEN + 4);

    // R8 brown-out disabled
    bod_en = 1'b0; bod_low = 1'b1;
    wait_cyc(20);
    chk(!sys_rst && rst_cause == 2'b10, "R8 brown-out ignored when disabled",
        {sys_rst, rst_cause}, 3'b010);

    // R7 brown-out enabled
    bod_en = 1'b1;
    wait_cyc(30);
    chk(sys_rst && !lp_hold && rst_cause == 2'b11, "R7 brown-out hold",
        {sys_rst, lp_hold, rst_cause}, 4'b1011);

    // R9 pin overrides brown-out, then brown-out resumes
    ext_rst_n = 1'b0;
    wait_cyc(PMIN + 5);
    chk(lp_hold && rst_cause == 2'b10, "R9 pin over brown-out", {lp_hold, rst_cause}, 3'b110);
    ext_rst_n = 1'b1;
    wait_cyc(5);
    chk(sys_rst && !lp_hold && rst_cause == 2'b11, "R9 brown-out resumes",
        {sys_rst, lp_hold, rst_cause}, 4'b1011);
    bod_low = 1'b0;
    wait_cyc(SLEN + 6);
    chk(!sys_rst, "R7 released after recovery", int'(sys_rst), 0);

    // R9 restart of sequence by a pin hold mid-count
    pin_pulse(PMIN + 2);
    wait_cyc(8);
    pin_pulse(PMIN + 1);
    wait_cyc(SLEN - 2);
    chk(sys_rst == 1'b1, "R9 sequence restarted", int'(sys_rst), 1);
    wait_cyc(10);
    chk(!sys_rst && rst_cause == 2'b10, "R9 final release", {sys_rst, rst_cause}, 3'b010);

    // R9 brown-out during count restarts it
    pin_pulse(PMIN);
    wait_cyc(8);
    bod_low = 1'b1;
    wait_cyc(4);
    bod_low = 1'b0;
    wait_cyc(SLEN + 6);
    chk(!sys_rst && rst_cause == 2'b11, "R9 brown-out mid-count",
        {sys_rst, rst_cause}, 3'b011);

    wait_cyc(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule